// File: doc/BRIEF.md
# Reset Cause Flag Register

This block is an 8-bit status register. It records which reset source caused the most recent restart, so that firmware can read the cause after it starts running. Each reset source gives a one-cycle event pulse: power-on, the external reset pin, the watchdog and the on-chip debugger. A rising event sets that source's flag. Software clears a flag by writing zero to its bit. Writing one to a bit leaves that flag unchanged, so software can clear some flags and keep the others.

The register has its own asynchronous power-on reset, `por_rst_n`, which is kept apart from every other reset in the chip. While it is asserted, the power-on flag is forced to 1 and the other three flags are forced to 0. Resets other than power-on never clear the register, so flags from several resets build up until software clears them. If firmware clears the register early after boot, then after the next reset only that reset's flag is set, and it identifies the source.

Each flag bit is its own two-state machine, `rcf_flag_cell`:
- The states are `FLG_CLEAR` and `FLG_SET`.
- The transition set (`FLG_CLEAR` to `FLG_SET`) is taken on the source's event.
- The transition clear (`FLG_SET` to `FLG_CLEAR`) is taken on a write with a zero in the flag's bit, provided the event is not present in the same cycle.
- With no event and no clearing write, the machine holds its state.
- On power-on reset, the power-on cell enters `FLG_SET` and the other three cells enter `FLG_CLEAR`.

Top module: `rst_cause_reg`

## Requirements
- R1: After `por_rst_n` is released, with `reg_rd`=1, `reg_rdata` reads 8'h01.
- R2: Bits 7, 6, 5 and 2 of `reg_rdata` always read 0, and writing ones to those bits has no effect.
- R3: Bit 0 (power-on flag) is set by `evt_por`. It is cleared only by a write with `reg_wdata[0]`=0. No other event or write clears it.
- R4: Bit 1 (external flag) is set by `evt_ext` at the next clock edge.
- R5: Bit 3 (watchdog flag) is set by `evt_wdt` at the next clock edge.
- R6: Bit 4 (debug flag) is set by `evt_dbg` at the next clock edge.
- R7: On a clock edge with `reg_wr`=1, every flag whose `reg_wdata` bit is 0 clears. Every flag whose `reg_wdata` bit is 1 keeps its value.
- R8: If a flag's event and a clearing write to that flag arrive in the same cycle, the flag ends up set.
- R9: Events from resets other than power-on never clear other flags, so flags build up.
- R10: Asserting `por_rst_n` (low), without waiting for a clock edge, forces bit 0 to 1 and bits 1, 3 and 4 to 0.
- R11: `reg_rdata` is 0 while `reg_rd`=0. While `reg_rd`=1 it shows the flags in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| por_rst_n | input | 1 | Asynchronous power-on reset, active low |
| evt_por | input | 1 | Power-on reset event pulse |
| evt_ext | input | 1 | External pin reset event pulse |
| evt_wdt | input | 1 | Watchdog reset event pulse |
| evt_dbg | input | 1 | Debugger reset event pulse |
| reg_rd | input | 1 | Read strobe |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data; a 0 clears the flag in that bit |
| reg_rdata | output | 8 | Read data |

## Verification
Random cycles mix the four event pulses with writes whose data bits are random. Together they show whether each flag's set and clear paths are wired to the right bit, and whether a flag mistakenly clears another. Directed sequences cover three corner cases:
- An event and a clearing write to the same flag in one cycle, which separates set-wins from clear-wins.
- Writes of all ones, which show whether a one holds a flag and whether the reserved bits stay zero.
- A power-on reset asserted in the middle of a run, which shows whether the power-on flag survives while the other flags are wiped.

A run of non-power-on events with no writes checks that flags build up.

// File: rtl/rcf_pkg.sv
package rcf_pkg;
    localparam int REG_W   = 8;
    localparam int NUM_SRC = 4;
    // Source index -> register bit position (read by firmware)
    localparam int SRC_BIT [NUM_SRC] = '{0, 1, 3, 4};
    localparam logic [REG_W-1:0] LIVE_MASK = 8'h1B;

    typedef enum logic {
        FLG_CLEAR = 1'b0,
        FLG_SET   = 1'b1
    } flag_st_e;
endpackage

// File: rtl/rcf_flag_cell.sv
module rcf_flag_cell
    import rcf_pkg::*;
#(
    parameter flag_st_e RST_ST = FLG_CLEAR
) (
    input  logic clk,
    input  logic por_rst_n,
    input  logic set_evt,
    input  logic clr_req,
    output logic flag_o
);
    flag_st_e st_q, st_d;

    always_ff @(posedge clk or negedge por_rst_n) begin
        if (!por_rst_n) st_q <= RST_ST;
        else            st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            FLG_CLEAR: if (set_evt) st_d = FLG_SET;
            FLG_SET:   if (clr_req && !set_evt) st_d = FLG_CLEAR;
            default:   st_d = FLG_CLEAR;
        endcase
    end

    always_comb flag_o = (st_q == FLG_SET);
endmodule

// File: rtl/rcf_readback.sv
module rcf_readback #(
    parameter int W = 8
) (
    input  logic         rd_en,
    input  logic [W-1:0] flags,
    input  logic [W-1:0] live_mask,
    output logic [W-1:0] rdata
);
    always_comb rdata = rd_en ? (flags & live_mask) : '0;
endmodule

// File: rtl/rst_cause_reg.sv
module rst_cause_reg
    import rcf_pkg::*;
(
    input  logic             clk,
    input  logic             por_rst_n,
    input  logic             evt_por,
    input  logic             evt_ext,
    input  logic             evt_wdt,
    input  logic             evt_dbg,
    input  logic             reg_rd,
    input  logic             reg_wr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata
);
    logic [NUM_SRC-1:0] evt_v;
    logic [NUM_SRC-1:0] cell_q;
    logic [REG_W-1:0]   flags_q;

    assign evt_v = {evt_dbg, evt_wdt, evt_ext, evt_por};

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        logic clr_req;
        assign clr_req = reg_wr && !reg_wdata[SRC_BIT[i]];
        rcf_flag_cell #(
            .RST_ST((i == 0) ? FLG_SET : FLG_CLEAR)
        ) u_cell (
            .clk      (clk),
            .por_rst_n(por_rst_n),
            .set_evt  (evt_v[i]),
            .clr_req  (clr_req),
            .flag_o   (cell_q[i])
        );
    end

    always_comb begin
        flags_q = '0;
        for (int i = 0; i < NUM_SRC; i++) flags_q[SRC_BIT[i]] = cell_q[i];
    end

    rcf_readback #(.W(REG_W)) u_rb (
        .rd_en    (reg_rd),
        .flags    (flags_q),
        .live_mask(LIVE_MASK),
        .rdata    (reg_rdata)
    );
endmodule

// File: rtl/rst_cause_reg_chk.sv
module rst_cause_reg_chk (
    input logic       clk,
    input logic       por_rst_n,
    input logic       evt_por,
    input logic       evt_ext,
    input logic       evt_wdt,
    input logic       evt_dbg,
    input logic       reg_rd,
    input logic       reg_wr,
    input logic [7:0] reg_wdata,
    input logic [7:0] reg_rdata,
    input logic [7:0] flags_q
);
    a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!por_rst_n)
        (reg_rdata & 8'hE4) == 8'h00);

    a_r3_por_sticky: assert property (@(posedge clk) disable iff (!por_rst_n)
        (flags_q[0] && !(reg_wr && !reg_wdata[0])) |=> flags_q[0]);

    a_r5_wdt_sets: assert property (@(posedge clk) disable iff (!por_rst_n)
        evt_wdt |=> flags_q[3]);

    a_r8_set_wins: assert property (@(posedge clk) disable iff (!por_rst_n)
        (evt_ext && reg_wr && !reg_wdata[1]) |=> flags_q[1]);

    a_r7_one_holds: assert property (@(posedge clk) disable iff (!por_rst_n)
        (reg_wr && reg_wdata[4] && !evt_dbg) |=> $stable(flags_q[4]));

    a_r7_zero_clears: assert property (@(posedge clk) disable iff (!por_rst_n)
        (reg_wr && !reg_wdata[3] && !evt_wdt) |=> !flags_q[3]);

    a_r11_read_gate: assert property (@(posedge clk) disable iff (!por_rst_n)
        !reg_rd |-> (reg_rdata == 8'h00));
endmodule

bind rst_cause_reg rst_cause_reg_chk u_chk (
    .clk      (clk),
    .por_rst_n(por_rst_n),
    .evt_por  (evt_por),
    .evt_ext  (evt_ext),
    .evt_wdt  (evt_wdt),
    .evt_dbg  (evt_dbg),
    .reg_rd   (reg_rd),
    .reg_wr   (reg_wr),
    .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .flags_q  (flags_q)
);

// File: tb/rst_cause_reg_test.sv
module rst_cause_reg_test;
    logic       clk = 1'b0;
    logic       por_rst_n = 1'b0;
    logic       evt_por = 0, evt_ext = 0, evt_wdt = 0, evt_dbg = 0;
    logic       reg_rd = 1'b1, reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;

    int n_cmp = 0, n_bad = 0;
    logic [7:0] model = 8'h01;
    int cyc = 0;
    bit done = 0;

    always #2 clk = ~clk;   // 250 MHz

    rst_cause_reg uut (
        .clk(clk), .por_rst_n(por_rst_n),
        .evt_por(evt_por), .evt_ext(evt_ext), .evt_wdt(evt_wdt), .evt_dbg(evt_dbg),
        .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    function automatic logic [7:0] next_val(logic [7:0] cur, logic [3:0] e,
                                             logic wr, logic [7:0] wd);
        logic [7:0] n;
        n = cur;
        if (wr) n = n & wd;
        n = n | {3'b000, e[3], e[2], 1'b0, e[1], e[0]};
        return n & 8'h1B;
    endfunction

    task automatic check(string req, logic [7:0] exp);
        n_cmp++;
        if (reg_rdata !== exp) begin
            n_bad++;
            $display("FAIL %s: got %02h expected %02h", req, reg_rdata, exp);
        end
    endtask

    task automatic step(logic [3:0] e, logic wr, logic [7:0] wd, string req);
        @(negedge clk);
        {evt_dbg, evt_wdt, evt_ext, evt_por} = e;
        reg_wr = wr; reg_wdata = wd;
        @(posedge clk);
        model = next_val(model, e, wr, wd);
        #1;
        {evt_dbg, evt_wdt, evt_ext, evt_por} = 4'b0;
        reg_wr = 1'b0;
        check(req, model);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(posedge clk);
        @(negedge clk) por_rst_n = 1'b1;
        #1 check("R1", 8'h01);

        // R3: only a zero write to bit 0 clears it; other events do not
        step(4'b1110, 1'b0, 8'h00, "R3");
        step(4'b0000, 1'b1, 8'hFE, "R3");
        step(4'b0001, 1'b0, 8'h00, "R3");
        // clear all
        step(4'b0000, 1'b1, 8'h00, "R7");
        // single sources identify the reset
        step(4'b0010, 1'b0, 8'h00, "R4");
        step(4'b0000, 1'b1, 8'h00, "R7");
        step(4'b0100, 1'b0, 8'h00, "R5");
        step(4'b0000, 1'b1, 8'h00, "R7");
        step(4'b1000, 1'b0, 8'h00, "R6");
        // R9 accumulation
        step(4'b0010, 1'b0, 8'h00, "R9");
        step(4'b0100, 1'b0, 8'h00, "R9");
        // R2 / R7: writing all ones holds everything, reserved stay zero
        step(4'b0000, 1'b1, 8'hFF, "R2");
        // R7 selective clear of watchdog only
        step(4'b0000, 1'b1, 8'hF7, "R7");
        // R8: set wins over clear in same cycle
        step(4'b0100, 1'b1, 8'h00, "R8");
        step(4'b0011, 1'b1, 8'h00, "R8");

        // R11 read gate
        @(negedge clk) reg_rd = 1'b0;
        #1 check("R11", 8'h00);
        @(negedge clk) reg_rd = 1'b1;
        #1 check("R11", model);

        // random mix
        for (int k = 0; k < 400; k++) begin
            logic [3:0] e;
            logic       w;
            logic [7:0] d;
            e = 4'($urandom) & 4'($urandom);
            w = 1'($urandom);
            d = 8'($urandom);
            step(e, w, d, "R9 random");
        end

        // R10: asynchronous power-on reset mid-run
        step(4'b1110, 1'b1, 8'hFE, "R10 setup");
        @(negedge clk);
        #1 por_rst_n = 1'b0;
        #0.5;
        model = 8'h01;
        check("R10", 8'h01);
        @(negedge clk) por_rst_n = 1'b1;
        #1 check("R1", 8'h01);
        step(4'b0000, 1'b1, 8'hFE, "R3");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule